// File: doc/BRIEF.md
# Frame Writeback Control Sequencer

This block is the control side of a raster writeback engine that copies an incoming line stream into memory. Software programs a destination base address, split into a 32-bit low word and an 8-bit high byte for a 40-bit address space. It also programs a line pitch and a packed width/height word. Writing the start bit of the control word launches one frame. While the frame runs, the block shows the memory address at which the current line must be stored. For each line the downstream store logic reports as committed, the block steps that address by the pitch and counts the line.

The frame ends when the programmed number of lines has been committed, or earlier when software writes the abort bit. At that point the busy status drops. If the interrupt enable is set, an idle interrupt is raised and stays high until software writes the enable back to 0. The address, pitch and height are captured when the frame starts, so software may rewrite them during a frame to prepare the next one. Pixel packing, the memory bus and tiled layouts are handled elsewhere.

Top module: `frame_wb_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `frame_busy` and `irq` are 0, and the progress, base, high byte, pitch and dimension registers all read 0.
- R2: The control word at offset 0x00 reads 0x54 in bits 31:24 and 2'b01 in bits 23:22. It reads the interrupt enable in bit 2 and busy in bit 1. Bit 0 (start) and bit 14 (abort) always read 0, and all other bits read 0.
- R3: A control write with bit 0 set and bit 14 clear, made while idle, sets `frame_busy` from the next cycle and clears progress to 0. Such a write made while busy has no effect on the running frame.
- R4: While busy, `line_addr` equals B + n·P, modulo 2^40. B is {high byte, base low word with bits 1:0 forced to 0}, P is the pitch with bits 3:0 forced to 0, and n is the progress count. The base (offset 0x04) reads back with bits 1:0 as 0, and the pitch (offset 0x0C) reads back with bits 3:0 as 0.
- R5: Each cycle with `line_done` high while busy adds one to the progress register (offset 0x14). `line_done` while idle changes nothing.
- R6: With the size-minus-one option set, a frame is H+1 lines long, where H is the height field. Without the option it is H lines long, and a height of 0 counts as 1. `frame_busy` falls in the cycle after the last line is committed, and progress then reads the line count.
- R7: A control write with bit 14 set, made while busy, clears `frame_busy` on the next cycle and leaves progress unchanged. Abort takes priority over a start bit in the same write. An abort while idle has no effect.
- R8: When a frame ends, `irq` rises in the same cycle that `frame_busy` falls, provided the interrupt enable (control bit 2, after any write in that cycle) is 1. `irq` then stays high until a control write with bit 2 clear. `irq` is never high while the enable is 0.
- R9: Writes to the base, high byte, pitch or dimension registers while busy update their readback but do not change the running frame's addresses or length.
- R10: The dimension register at offset 0x10 holds height in bits 31:16 and width in bits 15:0, and reads back as written.
- R11: The high address register at offset 0x08 keeps bits 7:0 of a write and reads 0 in bits 31:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| line_done | input | 1 | One line committed to memory this cycle |
| frame_busy | output | 1 | Frame in progress |
| line_addr | output | 40 | Memory address of the current line |
| irq | output | 1 | Idle interrupt, level |

## Verification
The hardest cases to reach are the ones where two events land in the same cycle or where configuration changes while a frame is running. The stimulus therefore rewrites the pitch, base and height in the middle of a frame and issues a second start write while busy. It sends lines back to back with no gap, and it writes an abort with the enable set. It also tries an abort while idle and a combined start-plus-abort write, then reads the progress register to show that no frame started. A behavioural model tracks busy, the interrupt and the expected line address on every clock.

// File: rtl/wbk_pkg.sv
// Shared constants for the frame writeback sequencer.
// Assumes a 40-bit memory address made from a 32-bit low word and a high byte.
package wbk_pkg;
    parameter int REG_AW  = 5;
    parameter int DATA_W  = 32;
    parameter int ADDR_W  = 40;
    parameter int DIM_W   = 16;
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int CNT_W  = DIM_W + 1;

    localparam logic [REG_AW-1:0] OFF_CTRL  = 5'h00;
    localparam logic [REG_AW-1:0] OFF_BASE  = 5'h04;
    localparam logic [REG_AW-1:0] OFF_HIGH  = 5'h08;
    localparam logic [REG_AW-1:0] OFF_PITCH = 5'h0C;
    localparam logic [REG_AW-1:0] OFF_DIM   = 5'h10;
    localparam logic [REG_AW-1:0] OFF_PROG  = 5'h14;

    localparam int BIT_START = 0;
    localparam int BIT_BUSY  = 1;
    localparam int BIT_IEN   = 2;
    localparam int BIT_STOP  = 14;

    localparam logic [7:0] ID_BYTE = 8'h54;
    localparam logic [1:0] REV_BITS = 2'b01;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [DATA_W-1:0] pitch;
        logic [DIM_W-1:0]  height;
    } frame_cfg_t;
endpackage

// File: rtl/wbk_regs.sv
// Register file and readback mux for the writeback sequencer.
// Decodes start/abort commands from control writes. It assumes one register
// access per cycle and masks the alignment bits of base and pitch.
module wbk_regs
    import wbk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic [CNT_W-1:0]  progress,
    output frame_cfg_t        cfg,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              ien,
    output logic              ien_next
);
    logic [DATA_W-1:0] base_lo_q;
    logic [HI_W-1:0]   base_hi_q;
    logic [DATA_W-1:0] pitch_q;
    logic [DATA_W-1:0] dim_q;
    logic              ctrl_wr;

    // Control write decode and the command pulses it produces.
    always_comb begin
        ctrl_wr   = bus_wr && (bus_addr == OFF_CTRL);
        cmd_stop  = ctrl_wr && bus_wdata[BIT_STOP];
        cmd_start = ctrl_wr && bus_wdata[BIT_START] && !bus_wdata[BIT_STOP];
        ien_next  = ctrl_wr ? bus_wdata[BIT_IEN] : ien;
    end

    // Storage of the configuration registers and the interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            pitch_q   <= '0;
            dim_q     <= '0;
            ien       <= 1'b0;
        end else begin
            ien <= ien_next;
            if (bus_wr) begin
                case (bus_addr)
                    OFF_BASE:  base_lo_q <= bus_wdata;
                    OFF_HIGH:  base_hi_q <= bus_wdata[HI_W-1:0];
                    OFF_PITCH: pitch_q   <= bus_wdata;
                    OFF_DIM:   dim_q     <= bus_wdata;
                    default:   ;
                endcase
            end
        end
    end

    // Aligned configuration presented to the frame sequencer.
    always_comb begin
        cfg.base   = {base_hi_q, base_lo_q[DATA_W-1:2], 2'b00};
        cfg.pitch  = {pitch_q[DATA_W-1:4], 4'b0000};
        cfg.height = dim_q[DATA_W-1:DATA_W-DIM_W];
    end

    // Readback multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL: begin
                bus_rdata[31:24]    = ID_BYTE;
                bus_rdata[23:22]    = REV_BITS;
                bus_rdata[BIT_IEN]  = ien;
                bus_rdata[BIT_BUSY] = busy;
            end
            OFF_BASE:  bus_rdata = {base_lo_q[DATA_W-1:2], 2'b00};
            OFF_HIGH:  bus_rdata = {{(DATA_W-HI_W){1'b0}}, base_hi_q};
            OFF_PITCH: bus_rdata = {pitch_q[DATA_W-1:4], 4'b0000};
            OFF_DIM:   bus_rdata = dim_q;
            OFF_PROG:  bus_rdata = {{(DATA_W-CNT_W){1'b0}}, progress};
            default:   bus_rdata = '0;
        endcase
    end

    // R2: start is a pulse, so a control write of start never leaves the enable changed unless bit 2 was written
    p_ien_follows_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_wr) |-> ien == $past(bus_wdata[BIT_IEN]));
endmodule

// File: rtl/wbk_frame_seq.sv
// Frame sequencer: captures the configuration at start, steps the line address
// by the pitch for every committed line, counts lines and ends the frame.
// Assumes line_done is a one-cycle-per-line strobe from the store logic.
module wbk_frame_seq
    import wbk_pkg::*;
#(
    parameter bit SIZE_MINUS_ONE = 1'b1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  frame_cfg_t        cfg,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              line_done,
    output logic              busy,
    output logic [ADDR_W-1:0] line_addr,
    output logic [CNT_W-1:0]  progress,
    output logic              frame_end
);
    logic [DATA_W-1:0] step_q;
    logic [CNT_W-1:0]  total_q;
    logic [CNT_W-1:0]  lines_req;
    logic              start_ok;
    logic              last_line;

    // Number of lines the programmed height asks for.
    generate
        if (SIZE_MINUS_ONE) begin : g_minus_one
            assign lines_req = {1'b0, cfg.height} + 1'b1;
        end else begin : g_exact
            assign lines_req = (cfg.height == '0) ? CNT_W'(1) : {1'b0, cfg.height};
        end
    endgenerate

    // Start, last-line and end-of-frame conditions.
    always_comb begin
        start_ok  = cmd_start && !busy;
        last_line = (progress + 1'b1) == total_q;
        frame_end = busy && (cmd_stop || (line_done && last_line));
    end

    // Frame state, captured configuration, address accumulator and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            line_addr <= '0;
            step_q    <= '0;
            total_q   <= '0;
            progress  <= '0;
        end else if (busy && cmd_stop) begin
            busy <= 1'b0;
        end else if (start_ok) begin
            busy      <= 1'b1;
            line_addr <= cfg.base;
            step_q    <= cfg.pitch;
            total_q   <= lines_req;
            progress  <= '0;
        end else if (busy && line_done) begin
            progress  <= progress + 1'b1;
            line_addr <= line_addr + {{HI_W{1'b0}}, step_q};
            if (last_line) busy <= 1'b0;
        end
    end

    // R3: a frame only begins after a start command
    p_start_needs_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_start) && progress == '0);
    // R4: each committed line moves the address by exactly one pitch
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy && line_done && !cmd_stop) && busy |-> line_addr == $past(line_addr) + {{HI_W{1'b0}}, step_q});
    // R9: without a committed line the address is held during the frame
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$past(line_done) |-> $stable(line_addr));
    // R6: the counter never passes the captured line total
    p_prog_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> progress < total_q);
    // R7: an abort while busy ends the frame and freezes the count
    p_abort_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_stop |=> !busy && $stable(progress));
endmodule

// File: rtl/wbk_irq.sv
// Idle interrupt: set when a frame ends with the enable on, held until the
// enable is written to 0. Assumes ien_next is the enable after this cycle's write.
module wbk_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic ien,
    input  logic ien_next,
    output logic irq
);
    // Pending flag, qualified by the enable as it will be after this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (irq || frame_end) && ien_next;
    end

    // R8: interrupt is gated by the enable register
    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien);
    // R8: interrupt rises only when a frame has just ended
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(frame_end));
endmodule

// File: rtl/frame_wb_sequencer.sv
// Top of the frame writeback sequencer: register file, frame sequencer and
// idle interrupt. Assumes the store logic pulses line_done once per line.
module frame_wb_sequencer
    import wbk_pkg::*;
#(
    parameter bit SIZE_MINUS_ONE = 1'b1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              line_done,
    output logic              frame_busy,
    output logic [ADDR_W-1:0] line_addr,
    output logic              irq
);
    frame_cfg_t       cfg;
    logic             cmd_start;
    logic             cmd_stop;
    logic             ien;
    logic             ien_next;
    logic [CNT_W-1:0] progress;
    logic             frame_end;

    wbk_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (frame_busy),
        .progress  (progress),
        .cfg       (cfg),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .ien       (ien),
        .ien_next  (ien_next)
    );

    wbk_frame_seq #(.SIZE_MINUS_ONE(SIZE_MINUS_ONE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .line_done (line_done),
        .busy      (frame_busy),
        .line_addr (line_addr),
        .progress  (progress),
        .frame_end (frame_end)
    );

    wbk_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .ien       (ien),
        .ien_next  (ien_next),
        .irq       (irq)
    );

    // R5: line_done while idle leaves the count unchanged
    p_idle_lines_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_busy && !cmd_start |=> $stable(progress));
endmodule

// File: tb/frame_wb_sequencer_tb_top.sv
module frame_wb_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        line_done = 1'b0;
    logic        frame_busy;
    logic [39:0] line_addr;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    frame_wb_sequencer #(.SIZE_MINUS_ONE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_done(line_done),
        .frame_busy(frame_busy), .line_addr(line_addr), .irq(irq)
    );

    // Behavioural reference model
    bit          m_busy, m_irq, m_ie;
    int          m_prog, m_total;
    longint      m_fbase, m_fpitch;
    logic [31:0] m_lo, m_hi, m_pitch, m_dim;

    always @(posedge clk) begin
        bit ctrl, fin, ie_n;
        if (!rst_n) begin
            m_busy = 0; m_irq = 0; m_ie = 0; m_prog = 0; m_total = 0;
            m_fbase = 0; m_fpitch = 0; m_lo = 0; m_hi = 0; m_pitch = 0; m_dim = 0;
        end else begin
            ctrl = bus_wr && bus_addr == 5'h00;
            ie_n = ctrl ? bus_wdata[2] : m_ie;
            fin = 0;
            if (ctrl && bus_wdata[14]) begin
                if (m_busy) begin m_busy = 0; fin = 1; end
            end else if (ctrl && bus_wdata[0] && !m_busy) begin
                m_busy = 1; m_prog = 0;
                m_fbase = {m_hi[7:0], m_lo[31:2], 2'b00};
                m_fpitch = {m_pitch[31:4], 4'b0};
                m_total = int'(m_dim[31:16]) + 1;
            end else if (m_busy && line_done) begin
                m_prog++;
                if (m_prog == m_total) begin m_busy = 0; fin = 1; end
            end
            m_irq = (m_irq || fin) && ie_n;
            m_ie = ie_n;
            if (bus_wr) begin
                case (bus_addr)
                    5'h04: m_lo = bus_wdata;
                    5'h08: m_hi = bus_wdata;
                    5'h0C: m_pitch = bus_wdata;
                    5'h10: m_dim = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 busy", frame_busy, m_busy);
            check("R8 irq", irq, m_irq);
            if (m_busy)
                check("R4 line_addr", line_addr, (m_fbase + longint'(m_prog) * m_fpitch) & 64'hFF_FFFF_FFFF);
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); bus_addr = a; #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic line(input int gap);
        @(negedge clk); line_done = 1;
        @(posedge clk); #1 line_done = 0;
        repeat (gap) @(posedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        rd(5'h00, 32'h5440_0000, "R1 R2 ctrl reset");
        rd(5'h14, 32'h0, "R1 progress reset");
        rd(5'h0C, 32'h0, "R1 pitch reset");
        rd(5'h10, 32'h0, "R1 dim reset");
        check("R1 irq reset", irq, 1'b0);

        wr(5'h04, 32'h1000_0003); rd(5'h04, 32'h1000_0000, "R4 base align");
        wr(5'h08, 32'h0000_01AB); rd(5'h08, 32'h0000_00AB, "R11 high byte");
        wr(5'h0C, 32'h0000_1007); rd(5'h0C, 32'h0000_1000, "R4 pitch align");
        wr(5'h10, 32'h0003_0040); rd(5'h10, 32'h0003_0040, "R10 dim");

        // Frame 1: four lines, enable on, config rewritten mid-frame
        wr(5'h00, 32'h5);
        rd(5'h00, 32'h5440_0006, "R2 R3 ctrl busy");
        check("R4 first addr", line_addr, 40'hAB_1000_0000);
        wr(5'h0C, 32'h2000); wr(5'h04, 32'h2000_0000); wr(5'h10, 32'h0009_0040);
        wr(5'h00, 32'h5);
        line(2);
        check("R9 addr after pitch rewrite", line_addr, 40'hAB_1000_1000);
        line(1); line(0);
        check("R4 addr line3", line_addr, 40'hAB_1000_3000);
        rd(5'h14, 32'd3, "R5 progress 3");
        check("R6 still busy", frame_busy, 1'b1);
        line(0);
        @(negedge clk);
        check("R6 busy falls", frame_busy, 1'b0);
        check("R8 irq raised", irq, 1'b1);
        rd(5'h14, 32'd4, "R6 progress final");
        line(0);
        rd(5'h14, 32'd4, "R5 idle line ignored");
        rd(5'h0C, 32'h2000, "R9 readback updated");
        wr(5'h00, 32'h0);
        check("R8 irq cleared", irq, 1'b0);

        // Frame 2: two back-to-back lines, enable off
        wr(5'h10, 32'h0001_0010);
        wr(5'h00, 32'h1);
        check("R4 new base", line_addr, 40'hAB_2000_0000);
        @(negedge clk); line_done = 1;
        @(posedge clk); @(posedge clk); #1 line_done = 0;
        @(negedge clk);
        check("R6 two lines", frame_busy, 1'b0);
        check("R8 no irq when disabled", irq, 1'b0);
        rd(5'h14, 32'd2, "R6 progress 2");

        // Frame 3: abort
        wr(5'h10, 32'h0007_0000);
        wr(5'h00, 32'h5);
        line(1);
        wr(5'h00, 32'h4004);
        check("R7 abort clears busy", frame_busy, 1'b0);
        check("R8 irq on abort", irq, 1'b1);
        rd(5'h14, 32'd1, "R7 progress held");
        wr(5'h00, 32'h4004);
        check("R7 abort idle", frame_busy, 1'b0);
        wr(5'h00, 32'h4005);
        check("R7 abort beats start", frame_busy, 1'b0);
        rd(5'h14, 32'd1, "R7 no frame started");
        wr(5'h00, 32'h0);
        check("R8 irq cleared again", irq, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule